// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Message Mailbox

This block moves 96-bit messages between a host processor and an I/O co-processor. It holds two independent 16-entry queues. The outbound queue carries messages from the host to the co-processor. The inbound queue carries them back. Both processors reach the same register window over a simple 64-bit register bus, and 32-bit software may use the low half for the control registers. Each message is split into a 64-bit leading word and a 32-bit trailing word. A sender first writes the leading word into a holding register. Writing the trailing word then commits the whole message to the queue. A receiver reads the leading word first. Reading the trailing word returns it together with queue occupancy and pointer fields, and removes the entry.

Four sticky interrupt conditions track the queues: outbound empty, outbound not empty, inbound empty and inbound not empty. A condition sets its latch in every cycle that it holds. The latch stays set after the queue state changes and clears only when software acknowledges it while the condition is false. Two level outputs present the latched send-empty and receive-not-empty conditions, each gated by its enable bit.

Top module: `mbx_top`

## Requirements
- R1: After reset both queues are empty. The control register reads bit 17 (empty) = 1 and bit 16 (full) = 0. The enable register at 0x48 reads 0. The latch register at 0x4C reads 0x5. Both interrupt outputs are low.
- R2: A write to the leading-word register (outbound 0x60, inbound 0x90) does not by itself enqueue anything. A write to the trailing-word register (outbound 0x68, inbound 0x98) enqueues the held leading word with write data bits 31:0 as one entry.
- R3: The head leading word reads at 0x70 (outbound) or 0xA0 (inbound). The head trailing word reads in bits 31:0 at 0x78 or 0xA8. A read at 0x78 or 0xA8 removes the head entry, and entries leave in the order they were written.
- R4: A queue reports full (control bit 16) once it holds 16 entries. A trailing-word write to a full queue is dropped and leaves the contents unchanged.
- R5: A read of the trailing-word register of an empty queue removes nothing and leaves the occupancy and pointer fields unchanged.
- R6: Trailing-word reads carry status in their upper bits. Bits 56:52 hold the occupancy (0 to 16). Bits 51:48 hold the free slots, capped at 15. Bits 47:44 hold the read pointer. Bits 43:40 hold the write pointer. Bits 63:57 and 39:32 read as zero.
- R7: The 4-bit pointers wrap from 15 to 0, and data stays correct across the wrap.
- R8: Latch bits at 0x4C are: 0 outbound empty, 1 outbound not empty, 2 inbound empty, 3 inbound not empty. A latch bit that is set stays set after its condition goes false, until a 1 is written to that bit at 0x4C.
- R9: An acknowledge of a bit whose condition is true in the same cycle leaves that bit set.
- R10: The send-empty output is latch bit 0 AND enable bit 0. The receive-not-empty output is latch bit 3 AND enable bit 3. Enables are written at 0x48.
- R11: Traffic on one queue does not change the other queue's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of a trailing-word receive register removes the head entry |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational from bus_addr |
| irq_send_empty | output | 1 | Latched outbound-empty condition, gated by its enable |
| irq_recv_not_empty | output | 1 | Latched inbound-not-empty condition, gated by its enable |

## Verification
The checker assumes the following about the bus. Only one of bus_wr and bus_rd is high in a cycle, and each access addresses a single register. A push and a pop on the same queue therefore never fall in the same cycle, so occupancy moves by at most one per cycle. The bench drives accesses one at a time on the falling edge and never raises both strobes together. This keeps every queue transition one step that the bench's arithmetic model of pointers and occupancy can predict.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DEPTH   = 16;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int LEAD_W  = 64;
  localparam int TRAIL_W = 32;
  localparam int NUM_IRQ = 4;

  localparam logic [7:0] ADR_IRQ_EN  = 8'h48;
  localparam logic [7:0] ADR_IRQ_ACK = 8'h4C;
  localparam logic [7:0] ADR_OUT_BASE = 8'h50;
  localparam logic [7:0] ADR_IN_BASE  = 8'h80;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_SEND0 = 8'h10;
  localparam logic [7:0] OFS_SEND1 = 8'h18;
  localparam logic [7:0] OFS_RECV0 = 8'h20;
  localparam logic [7:0] OFS_RECV1 = 8'h28;

  localparam logic [NUM_IRQ-1:0] LATCH_RST = 4'b0101;

  typedef struct packed {
    logic [LEAD_W-1:0]  lead;
    logic [TRAIL_W-1:0] trail;
  } mbx_msg_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
  import mbx_pkg::*;
#(
  parameter int DEP = DEPTH,
  localparam int PW = $clog2(DEP),
  localparam int CW = $clog2(DEP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  mbx_msg_t      push_msg,
  input  logic          pop,
  output mbx_msg_t      head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr
);
  mbx_msg_t      mem [DEP];
  logic          push_ok, pop_ok;
  logic [PW-1:0] wptr_nx, rptr_nx;
  logic [CW-1:0] count_nx;

  assign full    = (count == CW'(DEP));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  always_comb begin
    wptr_nx  = wptr;
    rptr_nx  = rptr;
    count_nx = count;
    if (push_ok) begin
      wptr_nx  = (wptr == PW'(DEP - 1)) ? '0 : wptr + 1'b1;
      count_nx = count_nx + 1'b1;
    end
    if (pop_ok) begin
      rptr_nx  = (rptr == PW'(DEP - 1)) ? '0 : rptr + 1'b1;
      count_nx = count_nx - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_nx;
      rptr  <= rptr_nx;
      count <= count_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_msg;
  end
endmodule

// File: rtl/mbx_dir.sv
module mbx_dir
  import mbx_pkg::*;
#(
  parameter logic [7:0] BASE = ADR_OUT_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [63:0]      bus_wdata,
  output logic [63:0]      rdata,
  output logic             full,
  output logic             empty,
  output logic             push_req,
  output logic [CNT_W-1:0] count
);
  logic [LEAD_W-1:0]  hold_q;
  logic               lead_wr, pop_req;
  logic [PTR_W-1:0]   wptr, rptr;
  logic [CNT_W-1:0]   free_slots;
  logic [3:0]         free_cap;
  mbx_msg_t           head, push_msg;

  assign lead_wr  = bus_wr && (bus_addr == BASE + OFS_SEND0);
  assign push_req = bus_wr && (bus_addr == BASE + OFS_SEND1);
  assign pop_req  = bus_rd && (bus_addr == BASE + OFS_RECV1);
  assign push_msg = '{lead: hold_q, trail: bus_wdata[TRAIL_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (lead_wr) hold_q <= bus_wdata;
  end

  mbx_fifo #(.DEP(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_req), .push_msg(push_msg),
    .pop(pop_req), .head(head), .full(full), .empty(empty),
    .count(count), .wptr(wptr), .rptr(rptr)
  );

  assign free_slots = CNT_W'(DEPTH) - count;
  assign free_cap   = (free_slots > CNT_W'(15)) ? 4'hF : 4'(free_slots);

  always_comb begin
    rdata = '0;
    if (bus_addr == BASE + OFS_CTRL)
      rdata = {46'b0, empty, full, 16'b0};
    else if (bus_addr == BASE + OFS_RECV0)
      rdata = head.lead;
    else if (bus_addr == BASE + OFS_RECV1)
      rdata = {7'b0, 5'(count), free_cap, 4'(rptr), 4'(wptr), 8'b0, head.trail};
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic               ack_wr,
  input  logic [NUM_IRQ-1:0] wbits,
  input  logic [NUM_IRQ-1:0] raw,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [NUM_IRQ-1:0] latch_q,
  output logic               irq_send_empty,
  output logic               irq_recv_not_empty
);
  logic [NUM_IRQ-1:0] ack_bits;

  assign ack_bits = ack_wr ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wbits;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_latch
    logic nx;
    assign nx = raw[i] | (latch_q[i] & ~ack_bits[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q[i] <= LATCH_RST[i];
      else        latch_q[i] <= nx;
    end
  end

  assign irq_send_empty     = latch_q[0] & en_q[0];
  assign irq_recv_not_empty = latch_q[3] & en_q[3];
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata,
  output logic        irq_send_empty,
  output logic        irq_recv_not_empty
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_i;
  logic [63:0]        dir_rdata [2];
  logic [1:0]         q_full, q_empty, q_push;
  logic [CNT_W-1:0]   q_count [2];
  logic [NUM_IRQ-1:0] raw, en_q, latch_q;
  logic               en_wr, ack_wr;
  logic [63:0]        irq_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    mbx_dir #(.BASE(d == 0 ? ADR_OUT_BASE : ADR_IN_BASE)) u_dir (
      .clk(clk), .rst_n(rst_n_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rdata(dir_rdata[d]),
      .full(q_full[d]), .empty(q_empty[d]), .push_req(q_push[d]),
      .count(q_count[d])
    );
  end

  assign raw    = {~q_empty[1], q_empty[1], ~q_empty[0], q_empty[0]};
  assign en_wr  = bus_wr && (bus_addr == ADR_IRQ_EN);
  assign ack_wr = bus_wr && (bus_addr == ADR_IRQ_ACK);

  mbx_irq u_irq (
    .clk(clk), .rst_n(rst_n_i), .en_wr(en_wr), .ack_wr(ack_wr),
    .wbits(bus_wdata[NUM_IRQ-1:0]), .raw(raw), .en_q(en_q),
    .latch_q(latch_q), .irq_send_empty(irq_send_empty),
    .irq_recv_not_empty(irq_recv_not_empty)
  );

  always_comb begin
    irq_rdata = '0;
    if (bus_addr == ADR_IRQ_EN)       irq_rdata[NUM_IRQ-1:0] = en_q;
    else if (bus_addr == ADR_IRQ_ACK) irq_rdata[NUM_IRQ-1:0] = latch_q;
  end

  assign bus_rdata = dir_rdata[0] | dir_rdata[1] | irq_rdata;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               out_full,
  input logic               out_empty,
  input logic               out_push,
  input logic [CNT_W-1:0]   out_count,
  input logic               ack_wr,
  input logic [NUM_IRQ-1:0] ack_bits,
  input logic [NUM_IRQ-1:0] raw,
  input logic [NUM_IRQ-1:0] en_q,
  input logic [NUM_IRQ-1:0] latch_q,
  input logic               irq_send_empty
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= CNT_W'(DEPTH)); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_full && out_empty)); // R4
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_full && out_push |=> out_count == $past(out_count)); // R4
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_push && !out_full |=> out_count == $past(out_count) + 1'b1); // R2
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q[1] && !(ack_wr && ack_bits[1]) |=> latch_q[1]); // R8
  AST_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    raw[0] |=> latch_q[0]); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_send_empty |-> en_q[0]); // R10
endmodule

bind mbx_top mbx_checker u_chk (
  .clk(clk), .rst_n(rst_n_i), .out_full(q_full[0]), .out_empty(q_empty[0]),
  .out_push(q_push[0]), .out_count(q_count[0]), .ack_wr(ack_wr),
  .ack_bits(bus_wdata[3:0]), .raw(raw), .en_q(en_q), .latch_q(latch_q),
  .irq_send_empty(irq_send_empty)
);

// File: tb/tb_mbx_top.sv
module tb_mbx_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        irq_send_empty, irq_recv_not_empty;
  int vec = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mbx_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_send_empty(irq_send_empty), .irq_recv_not_empty(irq_recv_not_empty)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  function automatic logic [63:0] lead_of(input int i);
    return 64'hA500_0000_0000_0000 + 64'(i) * 64'h0001_0000_0001;
  endfunction
  function automatic logic [31:0] trail_of(input int i);
    return 32'h5A00_0000 ^ 32'(i * 7 + 1);
  endfunction
  function automatic logic [63:0] status_word(input int cnt, input int rp,
                                              input int wp, input logic [31:0] t);
    int fr;
    fr = 16 - cnt;
    if (fr > 15) fr = 15;
    return {7'b0, 5'(cnt), 4'(fr), 4'(rp % 16), 4'(wp % 16), 8'b0, t};
  endfunction

  task automatic push(input logic [7:0] base, input int i);
    wr(base + 8'h10, lead_of(i));
    wr(base + 8'h18, {32'hFFFF_FFFF, trail_of(i)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int rp, wp;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) idle();

    // R1 reset state
    rd(8'h50, d); chk("R1 out ctrl", d, 64'h2_0000);
    rd(8'h80, d); chk("R1 in ctrl", d, 64'h2_0000);
    rd(8'h48, d); chk("R1 enables", d, 64'h0);
    rd(8'h4C, d); chk("R1 latches", d, 64'h5);
    chk("R1 irq outputs", {62'b0, irq_send_empty, irq_recv_not_empty}, 64'h0);

    // R2 leading word alone does not enqueue
    wr(8'h60, 64'hDEAD_BEEF_0000_0001);
    rd(8'h50, d); chk("R2 lead only", d, 64'h2_0000);

    // R2/R4 fill the outbound queue
    for (int i = 0; i < 16; i++) begin
      push(8'h50, i);
      rd(8'h50, d);
      chk("R4 fill ctrl", d, (i == 15) ? 64'h1_0000 : 64'h0);
    end
    push(8'h50, 99);  // dropped
    rd(8'h50, d); chk("R4 still full", d, 64'h1_0000);

    // R3/R6 drain in order with status fields
    for (int k = 0; k < 16; k++) begin
      rd(8'h70, d); chk("R3 lead word", d, lead_of(k));
      rd(8'h78, d); chk("R6 status+trail", d, status_word(16 - k, k, 0, trail_of(k)));
    end
    rd(8'h50, d); chk("R4 drop left empty", d, 64'h2_0000);

    // R5 pop on empty
    rd(8'h78, d); chk("R5 empty read", {32'b0, d[63:32]}, {32'b0, status_word(0, 0, 0, 0) >> 32});
    rd(8'h78, d); chk("R5 no pointer move", {32'b0, d[63:32]}, {32'b0, status_word(0, 0, 0, 0) >> 32});

    // R7 wrap with interleaved push/pop
    rp = 0; wp = 0;
    for (int j = 0; j < 20; j++) begin
      push(8'h50, 100 + j); wp++;
      rd(8'h70, d); chk("R7 wrap lead", d, lead_of(100 + j));
      rd(8'h78, d); chk("R7 wrap status", d, status_word(1, rp, wp, trail_of(100 + j)));
      rp++;
    end

    // R11 inbound independent of outbound
    for (int i = 0; i < 3; i++) push(8'h80, 200 + i);
    rd(8'h50, d); chk("R11 out unaffected", d, 64'h2_0000);
    rd(8'h80, d); chk("R11 in not empty", d, 64'h0);
    for (int k = 0; k < 3; k++) begin
      rd(8'hA0, d); chk("R11 in lead", d, lead_of(200 + k));
      rd(8'hA8, d); chk("R11 in status", d, status_word(3 - k, k, 3, trail_of(200 + k)));
    end

    // R8 sticky: not-empty conditions already gone
    rd(8'h4C, d); chk("R8 latched all", d, 64'hF);
    wr(8'h4C, 64'hF);
    rd(8'h4C, d); chk("R9 ack with empty true", d, 64'h5);

    // R10 gating
    wr(8'h48, 64'h9);
    chk("R10 send empty on", {63'b0, irq_send_empty}, 64'h1);
    chk("R10 recv idle", {63'b0, irq_recv_not_empty}, 64'h0);
    push(8'h80, 300);
    idle();
    chk("R10 recv on", {63'b0, irq_recv_not_empty}, 64'h1);
    rd(8'h4C, d); chk("R8 latches with msg", d, 64'hD);
    rd(8'hA8, d);
    idle();
    chk("R8 recv held after drain", {63'b0, irq_recv_not_empty}, 64'h1);
    wr(8'h4C, 64'h8);
    chk("R8 recv cleared by ack", {63'b0, irq_recv_not_empty}, 64'h0);
    rd(8'h4C, d); chk("R9 empty bits stay", d, 64'h5);
    wr(8'h48, 64'h0);
    chk("R10 send gated off", {63'b0, irq_send_empty}, 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule